// File: doc/BRIEF.md
# Dual Programmable Input Debouncer

This block cleans up two asynchronous input pins: a counting-clock pin and a gate pin. Each raw pin first passes through a synchronizer. A per-pin stability filter then forwards a new level to internal logic only after the synchronized pin has held that level for a programmable number of base-clock cycles. A level that reverts before the window is complete is discarded, and the forwarded level keeps its old value.

Each pin has its own setting input, and each setting is scaled by a fixed amount. The clock-pin window is the setting divided by 8, and the gate-pin window is the setting divided by 64, both truncated. The same window applies to rising and falling transitions. Besides the clean level, each pin has registered one-cycle strobes that mark rising and falling transitions of the filtered level. A setting that scales to a zero window turns the filter into a plain pass-through of the synchronized pin.

Top module: `pin_deglitch_pair`

## Requirements
- R1: While `rst` is high, and in the cycle after it, both filtered levels and all four strobes are 0.
- R2: The clock-pin window is W = floor(`clk_setting` / 8), so 47 gives 5. Count as edge 1 the first rising clock edge that samples a new raw level. If the level then holds, the filtered level changes at edge max(W,1)+2.
- R3: The gate-pin window is W = floor(`gate_setting` / 64), so 200 gives 3. A gate level held for exactly W cycles is forwarded, with the same edge count as R2.
- R4: A raw level change that lasts fewer than W cycles never reaches the filtered level. It produces no strobe, and the filtered level keeps its previous value.
- R5: The window and latency are the same for low-to-high and high-to-low transitions.
- R6: A return of the synchronized pin to the filtered level, even for one cycle, restarts the count. The new level must then hold for a full W cycles again.
- R7: When the scaled window is 0, the synchronized pin is forwarded every cycle. A one-cycle pulse then appears as a one-cycle filtered pulse, 3 edges after it is sampled.
- R8: A rise strobe (`*_rise`=1) is high for exactly the cycle in which the filtered level first reads 1 after reading 0. A fall strobe is high for the matching 1-to-0 cycle. The two strobes of a pin are never high together.
- R9: The two pins are filtered independently. Activity or settings on one pin do not change the timing or level of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_pin_raw | input | 1 | Asynchronous clock pin |
| gate_pin_raw | input | 1 | Asynchronous gate pin |
| clk_setting | input | SET_W | Clock-pin setting, window = value / 8 |
| gate_setting | input | SET_W | Gate-pin setting, window = value / 64 |
| clk_level | output | 1 | Filtered clock-pin level |
| clk_rise | output | 1 | One-cycle strobe on filtered clock-pin rise |
| clk_fall | output | 1 | One-cycle strobe on filtered clock-pin fall |
| gate_level | output | 1 | Filtered gate-pin level |
| gate_rise | output | 1 | One-cycle strobe on filtered gate-pin rise |
| gate_fall | output | 1 | One-cycle strobe on filtered gate-pin fall |

## Verification
A pin change driven just after cycle count t is due as a strobe in the cycle whose count reads t+2+max(W,1). Two of those cycles come from the synchronizer, and the rest come from the window count, where a zero window still costs one register. The driver computes W from the setting, pushes the expected direction and due cycle into a per-pin queue, and the monitor checks every strobe it sees against the head of that queue, cycle for cycle. Discarded glitches push nothing, so any strobe they caused would find an empty queue or a wrong due cycle. After each glitch the bench also reads the filtered level, and after the run it checks that both queues are empty.

// File: rtl/deglitch_pkg.sv
package deglitch_pkg;
  localparam int NUM_PINS = 2;
  localparam int PIN_CLK  = 0;
  localparam int PIN_GATE = 1;
endpackage

// File: rtl/dg_sync.sv
module dg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/dg_channel.sv
module dg_channel #(
  parameter int SET_W = 32,
  parameter int SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [SET_W-1:0] setting,
  output logic             level,
  output logic             rise,
  output logic             fall
);
  logic [SET_W-1:0] win;
  logic [SET_W-1:0] cnt, cnt_n;
  logic             lvl_n;

  // fixed per-pin scaling of the programmed value
  assign win = setting >> SHIFT;

  always_comb begin
    lvl_n = level;
    cnt_n = cnt;
    if (win == '0) begin
      lvl_n = din;
      cnt_n = '0;
    end else if (din == level) begin
      cnt_n = '0;
    end else if ((cnt + SET_W'(1)) >= win) begin
      lvl_n = din;
      cnt_n = '0;
    end else begin
      cnt_n = cnt + SET_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
      cnt   <= '0;
      rise  <= 1'b0;
      fall  <= 1'b0;
    end else begin
      level <= lvl_n;
      cnt   <= cnt_n;
      rise  <= lvl_n & ~level;
      fall  <= ~lvl_n & level;
    end
  end
endmodule

// File: rtl/pin_deglitch_pair.sv
module pin_deglitch_pair
  import deglitch_pkg::*;
#(
  parameter int SET_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int CLK_SHIFT   = 3,
  parameter int GATE_SHIFT  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_pin_raw,
  input  logic             gate_pin_raw,
  input  logic [SET_W-1:0] clk_setting,
  input  logic [SET_W-1:0] gate_setting,
  output logic             clk_level,
  output logic             clk_rise,
  output logic             clk_fall,
  output logic             gate_level,
  output logic             gate_rise,
  output logic             gate_fall
);
  logic [NUM_PINS-1:0] raw_v, sync_q, lvl_q, rise_q, fall_q;
  logic [SET_W-1:0]    set_v [NUM_PINS];

  assign raw_v[PIN_CLK]  = clk_pin_raw;
  assign raw_v[PIN_GATE] = gate_pin_raw;
  assign set_v[PIN_CLK]  = clk_setting;
  assign set_v[PIN_GATE] = gate_setting;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam int SH = (i == PIN_CLK) ? CLK_SHIFT : GATE_SHIFT;

    dg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw_v[i]),
      .q   (sync_q[i])
    );

    dg_channel #(.SET_W(SET_W), .SHIFT(SH)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .din     (sync_q[i]),
      .setting (set_v[i]),
      .level   (lvl_q[i]),
      .rise    (rise_q[i]),
      .fall    (fall_q[i])
    );
  end

  assign clk_level  = lvl_q[PIN_CLK];
  assign clk_rise   = rise_q[PIN_CLK];
  assign clk_fall   = fall_q[PIN_CLK];
  assign gate_level = lvl_q[PIN_GATE];
  assign gate_rise  = rise_q[PIN_GATE];
  assign gate_fall  = fall_q[PIN_GATE];
endmodule

// File: rtl/dg_checker.sv
module dg_checker #(
  parameter int N = 2
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] level,
  input logic [N-1:0] rise,
  input logic [N-1:0] fall,
  input logic [N-1:0] sync_lvl
);
  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (level == '0 && rise == '0 && fall == '0));

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(rise[i] && fall[i]));
    // R8
    rise_match_chk: assert property (@(posedge clk) disable iff (rst)
      rise[i] |-> (level[i] && !$past(level[i])));
    // R8
    fall_match_chk: assert property (@(posedge clk) disable iff (rst)
      fall[i] |-> (!level[i] && $past(level[i])));
    // R8
    edge_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (level[i] != $past(level[i])) |-> (rise[i] || fall[i]));
    // R4
    level_src_chk: assert property (@(posedge clk) disable iff (rst)
      (level[i] != $past(level[i])) |-> (level[i] == $past(sync_lvl[i])));
  end
endmodule

bind pin_deglitch_pair dg_checker #(.N(deglitch_pkg::NUM_PINS)) u_dg_chk (
  .clk      (clk),
  .rst      (rst),
  .level    (lvl_q),
  .rise     (rise_q),
  .fall     (fall_q),
  .sync_lvl (sync_q)
);

// File: tb/pin_deglitch_pair_bench.sv
module pin_deglitch_pair_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SET_W      = 32;

  typedef struct {
    bit dir;
    int at;
    int req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_pin_raw = 1'b0, gate_pin_raw = 1'b0;
  logic [SET_W-1:0] clk_setting = '0, gate_setting = '0;
  logic clk_level, clk_rise, clk_fall, gate_level, gate_rise, gate_fall;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t q_clk[$];
  exp_t q_gate[$];

  pin_deglitch_pair #(.SET_W(SET_W)) u_pin_deglitch_pair (
    .clk, .rst, .clk_pin_raw, .gate_pin_raw, .clk_setting, .gate_setting,
    .clk_level, .clk_rise, .clk_fall, .gate_level, .gate_rise, .gate_fall
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int win_of(input int p);
    int w;
    w = (p == 0) ? int'(clk_setting) / 8 : int'(gate_setting) / 64;
    return (w < 1) ? 1 : w;
  endfunction

  task automatic set_pin(input int p, input bit lvl, input bit pass, input int req);
    exp_t e;
    if (p == 0) clk_pin_raw = lvl; else gate_pin_raw = lvl;
    if (pass) begin
      e.dir = lvl; e.at = cyc + 2 + win_of(p); e.req = req;
      if (p == 0) q_clk.push_back(e); else q_gate.push_back(e);
    end
  endtask

  task automatic drive(input int p, input bit lvl, input int len, input bit pass, input int req);
    set_pin(p, lvl, pass, req);
    repeat (len) @(negedge clk);
  endtask

  task automatic check_lvl(input int p, input bit exp_v, input int req);
    logic got;
    got = (p == 0) ? clk_level : gate_level;
    checks++;
    if (got !== exp_v) begin
      errors++;
      $display("FAIL R%0d pin %0d level actual %b expected %b", req, p, got, exp_v);
    end
  endtask

  // monitor: every strobe is matched against the head of its queue
  task automatic chk_evt(input int p, input logic r, input logic f);
    exp_t e;
    bit empty;
    if (r || f) begin
      checks++;
      empty = (p == 0) ? (q_clk.size() == 0) : (q_gate.size() == 0);
      if (empty) begin
        errors++;
        $display("FAIL R4 pin %0d unexpected strobe rise=%b fall=%b actual cycle %0d expected none",
                 p, r, f, cyc);
      end else begin
        e = (p == 0) ? q_clk.pop_front() : q_gate.pop_front();
        if (e.dir != r || e.at != cyc || (r && f)) begin
          errors++;
          $display("FAIL R%0d pin %0d strobe actual dir %b cycle %0d expected dir %b cycle %0d",
                   e.req, p, r, cyc, e.dir, e.at);
        end
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk_evt(0, clk_rise, clk_fall);
      chk_evt(1, gate_rise, gate_fall);
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    clk_setting  = SET_W'(47);   // W = 5 (truncated)
    gate_setting = SET_W'(200);  // W = 3 (truncated)
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_lvl(0, 0, 1);
    check_lvl(1, 0, 1);
    checks++;
    if (clk_rise || clk_fall || gate_rise || gate_fall) begin
      errors++;
      $display("FAIL R1 strobes actual %b%b%b%b expected 0000", clk_rise, clk_fall, gate_rise, gate_fall);
    end

    // R2 clock pin rise after window of 5, R5 fall with same window
    drive(0, 1, 12, 1, 2);
    check_lvl(0, 1, 2);
    drive(0, 0, 12, 1, 5);
    check_lvl(0, 0, 5);

    // R4 high glitch of W-1 cycles is dropped
    drive(0, 1, 4, 0, 4);
    drive(0, 0, 12, 0, 4);
    check_lvl(0, 0, 4);

    // R4 low glitch while high is dropped, R5 in the falling direction
    drive(0, 1, 12, 1, 2);
    drive(0, 0, 4, 0, 4);
    drive(0, 1, 12, 0, 4);
    check_lvl(0, 1, 4);
    drive(0, 0, 12, 1, 5);

    // R6 bounce restarts the count; only the final stable run passes
    drive(0, 1, 4, 0, 6);
    drive(0, 0, 1, 0, 6);
    drive(0, 1, 4, 0, 6);
    drive(0, 0, 1, 0, 6);
    check_lvl(0, 0, 6);
    drive(0, 1, 12, 1, 6);
    check_lvl(0, 1, 6);
    drive(0, 0, 12, 1, 6);

    // R3 gate pin window of 3, pulse of exactly W passes
    drive(1, 1, 3, 1, 3);
    drive(1, 0, 12, 1, 3);
    check_lvl(1, 0, 3);
    // R3 gate pulse of W-1 dropped
    drive(1, 1, 2, 0, 3);
    drive(1, 0, 10, 0, 3);
    check_lvl(1, 0, 3);

    // R7 zero windows: single-cycle pulses pass on both pins
    clk_setting  = SET_W'(7);
    gate_setting = SET_W'(63);
    @(negedge clk);
    drive(0, 1, 1, 1, 7);
    drive(0, 0, 8, 1, 7);
    drive(1, 1, 1, 1, 7);
    drive(1, 0, 8, 1, 7);
    check_lvl(0, 0, 7);
    check_lvl(1, 0, 7);

    // R9 both pins at once with different windows
    clk_setting  = SET_W'(40);   // W = 5
    gate_setting = SET_W'(192);  // W = 3
    @(negedge clk);
    set_pin(0, 1, 1, 9);
    set_pin(1, 1, 1, 9);
    repeat (12) @(negedge clk);
    check_lvl(0, 1, 9);
    check_lvl(1, 1, 9);
    // gate falls for good while clock pin glitches low
    set_pin(1, 0, 1, 9);
    set_pin(0, 0, 0, 9);
    repeat (2) @(negedge clk);
    set_pin(0, 1, 0, 9);
    repeat (12) @(negedge clk);
    check_lvl(0, 1, 9);
    check_lvl(1, 0, 9);
    drive(0, 0, 12, 1, 9);

    repeat (10) @(negedge clk);
    // R4 R9 no expected event left unseen
    checks++;
    if (q_clk.size() != 0 || q_gate.size() != 0) begin
      errors++;
      $display("FAIL R9 pending events actual %0d/%0d expected 0/0", q_clk.size(), q_gate.size());
    end
    finish_run();
  end
endmodule